// File: doc/BRIEF.md
# DDR2 Column Burst Sequencer

This block sits on the device side of a DDR2-style SDRAM command bus. It handles column (read and write) accesses to a bank that has already been opened. On every rising clock edge it decodes the active-low select, row-strobe, column-strobe and write-enable pins. It enforces the minimum spacing between accepted column commands. It then produces, after the programmed read latency, the column address of every data beat of the burst. Two beats are transferred per clock, so each clock carries an even-lane address and an odd-lane address.

Burst length (4 or 8) and beat order (sequential or interleaved) are sampled together with each column command. A burst never leaves the aligned segment that holds its start column. A burst of eight may be cut short by a later accepted command, and the remaining beats of the old burst are then discarded. A command that arrives too early raises a one-clock violation flag and is dropped.

Top module: `col_burst_seq`

## Requirements
- R1: A column command is taken on a rising edge only when csN=0, rasN=1 and casN=0. Any other pin pattern starts no burst, raises no violation and does not count as a command for spacing.
- R2: weN=1 marks a read and weN=0 marks a write. isWrite is 1 during every valid clock of a write burst and 0 during a read burst.
- R3: The start column is the 11-bit value {colAddr[11], colAddr[9:0]}, and colAddr[10] has no effect. Every beat keeps the start column's bits above bit 1 (burst of four) or above bit 2 (burst of eight).
- R4: burstLen8=1 selects eight beats and 0 selects four. With interleave=0, the low bits of beat i are (start+i) mod BL. With interleave=1, they are start XOR i. During burst clock p, beatAddrA carries beat 2p and beatAddrB carries beat 2p+1.
- R5: With RL = addLat + casLat (casLat 2..7, addLat 0..7), dataValid is high in the clock that follows edge k+RL for a command taken at edge k. It stays high for BL/2 clocks.
- R6: Commands accepted at exactly the minimum spacing give back-to-back data clocks with no gap.
- R7: The minimum spacing from the last accepted command is 2 clocks when the new command asks for four beats and 4 clocks when it asks for eight. A command that comes earlier is ignored, tccdViol is 1 for the single clock after its edge, and the spacing count keeps running from the last accepted command.
- R8: When a newly accepted burst starts while an older burst is still running, the older burst's remaining beats are dropped. The new burst starts exactly RL clocks after its own command.
- R9: While rst_n=0, dataValid, isWrite, tccdViol and both beat addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low (1 = read) |
| colAddr | input | 12 | Column address pins; bit 10 is not part of the column |
| burstLen8 | input | 1 | 1 = burst of eight, 0 = burst of four, taken with the command |
| interleave | input | 1 | 1 = interleaved beat order, 0 = sequential |
| casLat | input | 3 | CAS latency in clocks |
| addLat | input | 3 | Additive latency in clocks |
| beatAddrA | output | 11 | Column of the even beat in the current data clock |
| beatAddrB | output | 11 | Column of the odd beat in the current data clock |
| dataValid | output | 1 | A burst data clock is in progress |
| isWrite | output | 1 | The current burst is a write |
| tccdViol | output | 1 | One-clock pulse for a command dropped for spacing |

## Verification
Single bursts are issued from start columns at every position within the segment, with both orders and both lengths. This separates modulo-wrap from XOR order and shows that the segment bits are kept. Setting colAddr[10] and sending non-column pin patterns shows that these inputs have no effect. Commands are issued at spacings of 1, 2, 3 and 4 clocks with mixed burst lengths. These runs tell gapless back-to-back bursts apart from dropped commands and from an eight-beat burst that a shorter one cuts off. A second latency setting shows that the data start tracks the sum of the two latencies.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;

  localparam int COL_W = 11;

  typedef struct packed {
    logic             load;
    logic             wr;
    logic             bl8;
    logic             ilv;
    logic [COL_W-1:0] startCol;
  } burst_strobe_t;

  // Column of beat number 'beat' inside the aligned segment of 'start'.
  function automatic logic [COL_W-1:0] beatCol(input logic [COL_W-1:0] start,
                                               input logic bl8,
                                               input logic ilv,
                                               input logic [2:0] beat);
    logic [2:0] lowMask;
    logic [2:0] low;
    lowMask = bl8 ? 3'b111 : 3'b011;
    low     = ilv ? (start[2:0] ^ beat) : (start[2:0] + beat);
    beatCol = (start & ~{{(COL_W-3){1'b0}}, lowMask}) |
              {{(COL_W-3){1'b0}}, (low & lowMask)};
  endfunction

endpackage

// File: rtl/col_burst_ctrl.sv
module col_burst_ctrl
  import col_burst_pkg::*;
#(
  parameter int CL_W    = 3,
  parameter int AL_W    = 3,
  parameter int GAP_BL4 = 2,
  parameter int GAP_BL8 = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csN,
  input  logic                rasN,
  input  logic                casN,
  input  logic                weN,
  input  logic [11:0]         colAddr,
  input  logic                burstLen8,
  input  logic                interleave,
  input  logic [CL_W-1:0]     casLat,
  input  logic [AL_W-1:0]     addLat,
  output burst_strobe_t       strobe,
  output logic                tccdViol
);

  localparam int DEPTH = (2**CL_W - 1) + (2**AL_W - 1);
  localparam int RL_W  = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(GAP_BL8 + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(GAP_BL8);

  logic             cmdSeen, tooSoon, accept;
  logic [CNT_W-1:0] sinceCnt, needGap;
  logic [RL_W-1:0]  rl, slot;
  burst_strobe_t    newEntry;
  burst_strobe_t    pipe     [DEPTH];
  burst_strobe_t    shiftSrc [DEPTH];
  logic             unusedCa10;

  assign unusedCa10 = colAddr[10];

  // command decode and spacing
  assign cmdSeen = !csN && rasN && !casN;
  assign needGap = burstLen8 ? CNT_W'(GAP_BL8) : CNT_W'(GAP_BL4);
  assign tooSoon = sinceCnt < needGap;
  assign accept  = cmdSeen && !tooSoon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sinceCnt <= CNT_SAT;
      tccdViol <= 1'b0;
    end else begin
      tccdViol <= cmdSeen && tooSoon;
      if (accept)                sinceCnt <= CNT_W'(1);
      else if (sinceCnt != CNT_SAT) sinceCnt <= sinceCnt + CNT_W'(1);
    end
  end

  // latency delay line: entry enters at slot RL-1, reaches slot 0 after RL-1 edges
  assign rl   = RL_W'(casLat) + RL_W'(addLat);
  assign slot = (rl == '0) ? '0 : rl - RL_W'(1);

  always_comb begin
    newEntry          = '0;
    newEntry.load     = 1'b1;
    newEntry.wr       = !weN;
    newEntry.bl8      = burstLen8;
    newEntry.ilv      = interleave;
    newEntry.startCol = {colAddr[11], colAddr[9:0]};
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_tail
      assign shiftSrc[i] = '0;
    end else begin : g_body
      assign shiftSrc[i] = pipe[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             pipe[i] <= '0;
      else if (accept && slot == RL_W'(i))    pipe[i] <= newEntry;
      else                                    pipe[i] <= shiftSrc[i];
    end
  end

  assign strobe = pipe[0];

  // R7: an ignored command never restarts the spacing count
  a_r7_ignored_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    tccdViol |-> (sinceCnt != CNT_W'(1)));

endmodule

// File: rtl/col_burst_dpath.sv
module col_burst_dpath
  import col_burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  burst_strobe_t    strobe,
  output logic [COL_W-1:0] beatAddrA,
  output logic [COL_W-1:0] beatAddrB,
  output logic             dataValid,
  output logic             isWrite
);

  localparam int LANES = 2;

  logic             active, wrR, bl8R, ilvR;
  logic [COL_W-1:0] startR;
  logic [1:0]       pairIdx, lastPair;
  logic [COL_W-1:0] laneAddr [LANES];

  assign lastPair = bl8R ? 2'd3 : 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      wrR     <= 1'b0;
      bl8R    <= 1'b0;
      ilvR    <= 1'b0;
      startR  <= '0;
      pairIdx <= '0;
    end else if (strobe.load) begin
      active  <= 1'b1;
      wrR     <= strobe.wr;
      bl8R    <= strobe.bl8;
      ilvR    <= strobe.ilv;
      startR  <= strobe.startCol;
      pairIdx <= '0;
    end else if (active) begin
      if (pairIdx == lastPair) active <= 1'b0;
      else                     pairIdx <= pairIdx + 2'd1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [2:0] beatNum;
    assign beatNum     = {pairIdx, (g == 1) ? 1'b1 : 1'b0};
    assign laneAddr[g] = active ? beatCol(startR, bl8R, ilvR, beatNum) : '0;
  end

  assign beatAddrA = laneAddr[0];
  assign beatAddrB = laneAddr[1];
  assign dataValid = active;
  assign isWrite   = active && wrR;

  // R5: a strobe from the control starts a burst at its first pair
  a_r5_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> (dataValid && pairIdx == 2'd0));

  // R5: a burst stops after its last pair when nothing new arrives
  a_r5_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (dataValid && pairIdx == lastPair && !strobe.load) |=> !dataValid);

  // R3: both beats of a data clock lie in the same eight-column block
  a_r3_same_segment: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> (beatAddrA[COL_W-1:3] == beatAddrB[COL_W-1:3]));

  // R4: the two beats of one clock never repeat a column
  a_r4_beats_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> (beatAddrA != beatAddrB));

endmodule

// File: rtl/col_burst_seq.sv
module col_burst_seq #(
  parameter int CL_W    = 3,
  parameter int AL_W    = 3,
  parameter int GAP_BL4 = 2,
  parameter int GAP_BL8 = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic [11:0]     colAddr,
  input  logic            burstLen8,
  input  logic            interleave,
  input  logic [CL_W-1:0] casLat,
  input  logic [AL_W-1:0] addLat,
  output logic [10:0]     beatAddrA,
  output logic [10:0]     beatAddrB,
  output logic            dataValid,
  output logic            isWrite,
  output logic            tccdViol
);

  col_burst_pkg::burst_strobe_t strobe;

  col_burst_ctrl #(
    .CL_W(CL_W), .AL_W(AL_W), .GAP_BL4(GAP_BL4), .GAP_BL8(GAP_BL8)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .colAddr(colAddr), .burstLen8(burstLen8), .interleave(interleave),
    .casLat(casLat), .addLat(addLat),
    .strobe(strobe), .tccdViol(tccdViol)
  );

  col_burst_dpath dpath_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .beatAddrA(beatAddrA), .beatAddrB(beatAddrB),
    .dataValid(dataValid), .isWrite(isWrite)
  );

endmodule

// File: tb/col_burst_seq_tb_top.sv
`timescale 1ns/1ps
module col_burst_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [11:0] colAddr = '0;
  logic        burstLen8 = 1'b0, interleave = 1'b0;
  logic [2:0]  casLat = 3'd3, addLat = 3'd0;
  logic [10:0] beatAddrA, beatAddrB;
  logic        dataValid, isWrite, tccdViol;

  col_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .colAddr(colAddr), .burstLen8(burstLen8), .interleave(interleave),
    .casLat(casLat), .addLat(addLat),
    .beatAddrA(beatAddrA), .beatAddrB(beatAddrB),
    .dataValid(dataValid), .isWrite(isWrite), .tccdViol(tccdViol)
  );

  always #4 clk = ~clk;  // 125 MHz

  int    checks = 0, fails = 0, cyc = 0, lastK = -1000;
  bit    monOn = 0, done = 0;
  string curReq = "R9";
  bit          expV [1024];
  bit          expW [1024];
  bit          expViol [1024];
  logic [10:0] expA [1024];
  logic [10:0] expB [1024];

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  function automatic logic [10:0] model(input logic [10:0] col, input bit bl8,
                                        input bit ilv, input int beat);
    int bl, low, seg, nl;
    bl  = bl8 ? 8 : 4;
    low = int'(col) % bl;
    seg = int'(col) - low;
    nl  = ilv ? (low ^ beat) : ((low + beat) % bl);
    return 11'(seg + nl);
  endfunction

  // per-clock comparison against the expectations the scenario tasks posted
  always @(negedge clk) begin
    if (monOn) begin
      int idx;
      idx = cyc % 1024;
      checks++;
      if (dataValid !== expV[idx] || tccdViol !== expViol[idx]) begin
        fails++;
        $display("FAIL %s cyc=%0d valid/viol=%0b%0b expected=%0b%0b", curReq, cyc,
                 dataValid, tccdViol, expV[idx], expViol[idx]);
      end
      if (expV[idx]) begin
        checks++;
        if (beatAddrA !== expA[idx] || beatAddrB !== expB[idx] || isWrite !== expW[idx]) begin
          fails++;
          $display("FAIL %s cyc=%0d beats=%h/%h wr=%0b expected=%h/%h wr=%0b", curReq, cyc,
                   beatAddrA, beatAddrB, isWrite, expA[idx], expB[idx], expW[idx]);
        end
      end
      expV[idx] = 0;
      expViol[idx] = 0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pins(input logic cs, input logic ras, input logic cas, input logic we);
    @(negedge clk);
    csN = cs; rasN = ras; casN = cas; weN = we;
    @(posedge clk);
    #1;
    csN = 1; rasN = 1; casN = 1; weN = 1;
  endtask

  // column command; posts the expected beats or violation
  task automatic issue(input bit wr, input logic [11:0] ca, input bit bl8, input bit ilv);
    int k, rl;
    logic [10:0] col;
    @(negedge clk);
    csN = 0; rasN = 1; casN = 0; weN = !wr;
    colAddr = ca; burstLen8 = bl8; interleave = ilv;
    @(posedge clk);
    #1;
    k = cyc;
    csN = 1; rasN = 1; casN = 1; weN = 1;
    rl  = int'(casLat) + int'(addLat);
    col = {ca[11], ca[9:0]};
    if (k - lastK < (bl8 ? 4 : 2)) begin
      expViol[k % 1024] = 1;
    end else begin
      lastK = k;
      for (int p = 0; p < (bl8 ? 4 : 2); p++) begin
        int idx;
        idx = (k + rl + p) % 1024;
        expV[idx] = 1;
        expW[idx] = wr;
        expA[idx] = model(col, bl8, ilv, 2*p);
        expB[idx] = model(col, bl8, ilv, 2*p + 1);
      end
    end
  endtask

  task automatic t_reset;
    curReq = "R9 reset state";
    @(negedge clk);
    checks++;
    if (dataValid !== 0 || isWrite !== 0 || tccdViol !== 0 || beatAddrA !== 0 || beatAddrB !== 0) begin
      fails++;
      $display("FAIL R9 outputs=%0b%0b%0b %h %h expected all zero", dataValid, isWrite,
               tccdViol, beatAddrA, beatAddrB);
    end
  endtask

  task automatic t_seq_bl4;
    curReq = "R4 sequential four-beat order / R5 latency";
    for (int s = 0; s < 4; s++) begin
      issue(0, 12'h120 + 12'(s), 0, 0);
      idle(3);
    end
    idle(20);
  endtask

  task automatic t_ilv_bl8;
    curReq = "R4 interleaved and sequential eight-beat order";
    issue(0, 12'h0A5, 1, 1);
    idle(5);
    issue(0, 12'h0A5, 1, 0);
    idle(5);
    issue(0, 12'h3FE, 1, 1);
    idle(20);
  endtask

  task automatic t_write;
    curReq = "R2 write flag";
    issue(1, 12'h011, 0, 0);
    idle(3);
    issue(1, 12'h0F7, 1, 1);
    idle(20);
  endtask

  task automatic t_ca10;
    curReq = "R3 colAddr[10] has no effect";
    issue(0, 12'hC06, 0, 1);
    idle(3);
    issue(0, 12'h40D, 1, 0);
    idle(20);
  endtask

  task automatic t_noncol;
    curReq = "R1 non-column pin patterns";
    pins(1, 1, 0, 1);
    pins(0, 0, 0, 1);
    pins(0, 0, 1, 1);
    pins(0, 1, 1, 0);
    issue(0, 12'h044, 1, 0);  // one clock after the last pattern: no violation
    idle(20);
  endtask

  task automatic t_gapless;
    curReq = "R6 back-to-back at minimum spacing";
    issue(0, 12'h101, 0, 0);
    idle(1);
    issue(1, 12'h20A, 0, 1);
    idle(1);
    issue(0, 12'h017, 0, 0);
    idle(20);
    issue(0, 12'h063, 1, 0);
    idle(3);
    issue(0, 12'h06C, 1, 1);
    idle(20);
  endtask

  task automatic t_spacing;
    curReq = "R7 spacing violation and drop";
    issue(0, 12'h030, 0, 0);
    issue(0, 12'h034, 0, 0);   // spacing 1: dropped
    issue(0, 12'h038, 0, 0);   // spacing 2 from the accepted one
    idle(20);
    issue(0, 12'h080, 1, 0);
    idle(1);
    issue(0, 12'h088, 1, 0);   // spacing 2 with eight beats: dropped
    idle(1);
    issue(0, 12'h090, 1, 0);   // spacing 4 from the accepted one
    idle(20);
    issue(0, 12'h0C1, 0, 0);
    idle(1);
    issue(0, 12'h0C9, 1, 0);   // eight beats after four at spacing 2: dropped
    idle(20);
  endtask

  task automatic t_interrupt;
    curReq = "R8 eight-beat burst cut short";
    issue(0, 12'h155, 1, 0);
    idle(1);
    issue(1, 12'h16A, 0, 1);   // spacing 2
    idle(20);
    issue(0, 12'h1E3, 1, 1);
    idle(2);
    issue(0, 12'h1F0, 0, 0);   // spacing 3
    idle(20);
  endtask

  task automatic t_latency;
    curReq = "R5 latency six";
    @(negedge clk);
    casLat = 3'd4; addLat = 3'd2;
    idle(2);
    issue(0, 12'h07B, 1, 1);
    idle(3);
    issue(0, 12'h2A2, 0, 0);
    idle(25);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk);
    rst_n = 1;
    monOn = 1;
    idle(2);
    t_seq_bl4;
    t_ilv_bl8;
    t_write;
    t_ca10;
    t_noncol;
    t_gapless;
    t_spacing;
    t_interrupt;
    t_latency;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule